// File: doc/BRIEF.md
# Two-Stage System Watchdog Timer

This block is a register-mapped system watchdog for a larger chip. A countdown counter steps down once for each cycle in which an external tick-enable input is high. Software arms the counter by writing the reload register, which copies the programmed timeout into the counter. Software can pause the countdown with a halt bit. When the counter runs out, it reloads itself from the timeout register and keeps counting. The first expiry raises a timeout status bit and the interrupt output.

If software has not cleared that timeout status by the next expiry, the block treats it as a hung system. It sets a second-stage flag and a boot flag, and it pulses a reboot request. A strap input is sampled during reset. When the strap is high, reboot requests are suppressed regardless of the software setting. Software reaches every register through a simple synchronous word bus. Writes take effect at the clock edge, and read data is combinational from the address.

Top module: `sys_watchdog`

## Requirements
- R1: After reset the registers read as follows: counter (address 0x0) 0, timeout (0x1) 4, status-1 (0x2) 0, status-2 (0x3) 0, control-1 (0x4) 0, control-2 (0x5) 0x0008, data-in (0x6) 0, data-out (0x7) 0, IRQ-generate (0x8) 0x03, config (0x9) equal to the sampled strap. Unmapped addresses read 0.
- R2: Any write to address 0x0 loads the timeout value into the counter. A stored timeout of 0 loads 1. While the counter runs, address 0x0 reads the remaining count, which drops by one on each cycle with the tick input high.
- R3: While control-1 bit 0 (halt) is 1, ticks leave the counter unchanged. Clearing the bit lets counting resume from the held value.
- R4: A counter loaded with N expires on exactly the Nth tick. After N-1 ticks it reads 1 with status-1 bit 0 still clear. On expiry it reloads the timeout value and keeps counting.
- R5: The timeout register keeps only its low 10 bits. Writing 0xFFFF reads back 0x03FF and then expires after 1023 ticks.
- R6: Each expiry sets status-1 bit 0. The irq_o output is high whenever any status-1 bit (0, 1 or 2) is set.
- R7: An expiry that occurs while status-1 bit 0 is already set also sets status-2 bit 0 (second timeout) and bit 1 (boot). If the effective no-reboot bit (config bit 0) is 0, it additionally pulses reboot_o high for exactly one cycle.
- R8: strap_i is captured while reset is asserted. If the captured strap is 1, config bit 0 reads 1 and cannot be cleared, and reboot_o never rises. If it is 0, software sets and clears config bit 0 freely.
- R9: Status bits are write-one-to-clear: writing back the value just read leaves 0. A bit that is being set in the same cycle as its clear stays set.
- R10: Writing 1 to control-1 bit 1 (lock) sets it. Later writes of 0 leave it set until reset.
- R11: A write to data-in (0x6) sets status-1 bit 1. A write to data-out (0x7) sets status-1 bit 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Register word address |
| bus_wen | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| tick_i | input | 1 | Countdown enable, one step per high cycle |
| strap_i | input | 1 | No-reboot strap, captured during reset |
| irq_o | output | 1 | Interrupt request, OR of status-1 bits |
| reboot_o | output | 1 | One-cycle reboot request on second timeout |

## Verification
The embedded assertions check several properties on every cycle. A reload lands the effective timeout in the counter, and a halted counter holds its value. A running counter steps down by exactly one. The lock bit never falls, a reboot pulse is always accompanied by the second-timeout flag, and a high strap keeps reboot_o low. Other behaviour can only be shown by the bench's scenarios. These cover the exact tick on which the first and second expiry land, the 10-bit masking at the maximum timeout, and the zero-timeout case. They also cover the write-one-to-clear sequences including a clear that collides with an expiry, the data-register side effects, and the strap sampled high against software attempts to clear the no-reboot bit.

// File: rtl/wdt_pkg.sv
// Package: shared address map and widths for the system watchdog.
// Assumes a word-addressed register bus with a 4-bit address.
package wdt_pkg;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 16;
    localparam int BYTE_W = 8;
    localparam int S1_W   = 3;
    localparam int S2_W   = 2;

    typedef enum logic [ADDR_W-1:0] {
        A_COUNT = 4'h0,
        A_TMO   = 4'h1,
        A_STAT1 = 4'h2,
        A_STAT2 = 4'h3,
        A_CTRL1 = 4'h4,
        A_CTRL2 = 4'h5,
        A_DIN   = 4'h6,
        A_DOUT  = 4'h7,
        A_SWIRQ = 4'h8,
        A_CFG   = 4'h9
    } wdt_addr_e;

    localparam logic [DATA_W-1:0] CTRL2_RST = 16'h0008;
    localparam logic [BYTE_W-1:0] SWIRQ_RST = 8'h03;
endpackage

// File: rtl/wdt_countdown.sv
// Module: wdt_countdown
// Countdown counter of the watchdog. A load copies the timeout into the
// counter, with a timeout of 0 treated as 1. Each tick while running steps
// the counter down by one. Reaching the end pulses expire_o and reloads.
// Assumes: load has priority over a tick in the same cycle; a counter of 0
// (never loaded since reset) ignores ticks.
module wdt_countdown #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] tmo_i,
    input  logic             run_i,
    input  logic             tick_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             expire_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] tmo_eff;
    logic             step;

    // Effective reload value and the step/expiry decode.
    always_comb begin
        tmo_eff  = (tmo_i == '0) ? ONE : tmo_i;
        step     = run_i && tick_i && !load_i && (cnt_q != '0);
        expire_o = step && (cnt_q == ONE);
    end

    // Counter register: load, reload on expiry, or decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= tmo_eff;
        end else if (step) begin
            cnt_q <= expire_o ? tmo_eff : cnt_q - ONE;
        end
    end

    assign cnt_o = cnt_q;

    // R2
    load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_q == $past(tmo_eff)));

    // R3
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !load_i) |=> $stable(cnt_q));

    // R4
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && tick_i && !load_i && cnt_q > ONE) |=> (cnt_q == $past(cnt_q) - ONE));
endmodule

// File: rtl/wdt_regs.sv
// Module: wdt_regs
// Software-visible control storage: timeout, control-1 (halt, sticky lock),
// control-2, data-in/out bytes, IRQ-generate byte and no-reboot config.
// It also captures the strap during reset.
// Assumes: write strobes are already decoded per register by the top.
module wdt_regs #(
    parameter int TMR_W  = 10,
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              wr_tmo_i,
    input  logic              wr_ctrl1_i,
    input  logic              wr_ctrl2_i,
    input  logic              wr_din_i,
    input  logic              wr_dout_i,
    input  logic              wr_swirq_i,
    input  logic              wr_cfg_i,
    output logic [TMR_W-1:0]  tmo_o,
    output logic              halt_o,
    output logic              lock_o,
    output logic [DATA_W-1:0] ctrl2_o,
    output logic [BYTE_W-1:0] din_o,
    output logic [BYTE_W-1:0] dout_o,
    output logic [BYTE_W-1:0] swirq_o,
    output logic              strap_o,
    output logic              noreboot_o
);
    import wdt_pkg::*;

    logic [TMR_W-1:0]  tmo_q;
    logic              halt_q, lock_q, strap_q, sw_nrb_q;
    logic [DATA_W-1:0] ctrl2_q;
    logic [BYTE_W-1:0] din_q, dout_q, swirq_q;

    // Timeout register, masked to its implemented width.
    always_ff @(posedge clk) begin
        if (!rst_n)        tmo_q <= TMR_W'(4);
        else if (wr_tmo_i) tmo_q <= wdata_i[TMR_W-1:0];
    end

    // Control-1: halt is plain read/write, lock can only be set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt_q <= 1'b0;
            lock_q <= 1'b0;
        end else if (wr_ctrl1_i) begin
            halt_q <= wdata_i[0];
            lock_q <= lock_q | wdata_i[1];
        end
    end

    // Control-2 and the byte-wide storage registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl2_q <= CTRL2_RST;
            din_q   <= '0;
            dout_q  <= '0;
            swirq_q <= SWIRQ_RST;
        end else begin
            if (wr_ctrl2_i) ctrl2_q <= wdata_i;
            if (wr_din_i)   din_q   <= wdata_i[BYTE_W-1:0];
            if (wr_dout_i)  dout_q  <= wdata_i[BYTE_W-1:0];
            if (wr_swirq_i) swirq_q <= wdata_i[BYTE_W-1:0];
        end
    end

    // Strap capture during reset and the software no-reboot bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strap_q  <= strap_i;
            sw_nrb_q <= 1'b0;
        end else if (wr_cfg_i) begin
            sw_nrb_q <= wdata_i[0];
        end
    end

    assign tmo_o      = tmo_q;
    assign halt_o     = halt_q;
    assign lock_o     = lock_q;
    assign ctrl2_o    = ctrl2_q;
    assign din_o      = din_q;
    assign dout_o     = dout_q;
    assign swirq_o    = swirq_q;
    assign strap_o    = strap_q;
    assign noreboot_o = strap_q | sw_nrb_q;

    // R10
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q);

    // R8
    strap_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(strap_q));
endmodule

// File: rtl/wdt_status.sv
// Module: wdt_status
// Two-stage status logic. Every expiry sets stage-1 timeout. An expiry that
// finds stage-1 timeout still set raises second-timeout and boot flags and,
// unless no-reboot is in force, a one-cycle reboot pulse. All bits are W1C,
// with a set winning over a clear in the same cycle.
// Assumes: expire_i is a single-cycle pulse from the countdown.
module wdt_status #(
    parameter int S1_W = 3,
    parameter int S2_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            expire_i,
    input  logic            set_smi_i,
    input  logic            set_int_i,
    input  logic            noreboot_i,
    input  logic            wr_s1_i,
    input  logic            wr_s2_i,
    input  logic [S1_W-1:0] clr_s1_i,
    input  logic [S2_W-1:0] clr_s2_i,
    output logic [S1_W-1:0] s1_o,
    output logic [S2_W-1:0] s2_o,
    output logic            reboot_o
);
    logic [S1_W-1:0] s1_q, s1_set, s1_clr;
    logic [S2_W-1:0] s2_q, s2_set, s2_clr;
    logic            second, reboot_q;

    // Set and clear vectors for both status registers.
    always_comb begin
        second = expire_i && s1_q[0];
        s1_set = '0;
        s1_set[0] = expire_i;
        s1_set[1] = set_smi_i;
        s1_set[2] = set_int_i;
        s2_set = second ? {S2_W{1'b1}} : '0;
        s1_clr = wr_s1_i ? clr_s1_i : '0;
        s2_clr = wr_s2_i ? clr_s2_i : '0;
    end

    // Status registers and the reboot pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q     <= '0;
            s2_q     <= '0;
            reboot_q <= 1'b0;
        end else begin
            s1_q     <= (s1_q & ~s1_clr) | s1_set;
            s2_q     <= (s2_q & ~s2_clr) | s2_set;
            reboot_q <= second && !noreboot_i;
        end
    end

    assign s1_o     = s1_q;
    assign s2_o     = s2_q;
    assign reboot_o = reboot_q;

    // R7
    reboot_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reboot_q |-> (s2_q[0] && s2_q[1]));

    // R7
    reboot_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reboot_q |=> !reboot_q);

    // R6
    expiry_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire_i |=> s1_q[0]);
endmodule

// File: rtl/sys_watchdog.sv
// Module: sys_watchdog (top)
// Two-stage system watchdog. This module decodes the register bus into
// per-register strobes, wires counter, control storage and status logic,
// and builds the combinational read mux.
// Assumes: TMR_W < DATA_W; at most one write per cycle.
module sys_watchdog #(
    parameter int TMR_W = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  bus_addr,
    input  logic        bus_wen,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        tick_i,
    input  logic        strap_i,
    output logic        irq_o,
    output logic        reboot_o
);
    import wdt_pkg::*;

    localparam int PAD_T = DATA_W - TMR_W;
    localparam int PAD_B = DATA_W - BYTE_W;

    logic              wr_cnt, wr_tmo, wr_s1, wr_s2, wr_c1, wr_c2;
    logic              wr_din, wr_dout, wr_swirq, wr_cfg;
    logic [TMR_W-1:0]  tmo, cnt;
    logic              halt, lock, strap_q, noreboot, expire;
    logic [DATA_W-1:0] ctrl2;
    logic [BYTE_W-1:0] din, dout, swirq;
    logic [S1_W-1:0]   s1;
    logic [S2_W-1:0]   s2;

    // Per-register write strobes.
    always_comb begin
        wr_cnt   = bus_wen && (bus_addr == A_COUNT);
        wr_tmo   = bus_wen && (bus_addr == A_TMO);
        wr_s1    = bus_wen && (bus_addr == A_STAT1);
        wr_s2    = bus_wen && (bus_addr == A_STAT2);
        wr_c1    = bus_wen && (bus_addr == A_CTRL1);
        wr_c2    = bus_wen && (bus_addr == A_CTRL2);
        wr_din   = bus_wen && (bus_addr == A_DIN);
        wr_dout  = bus_wen && (bus_addr == A_DOUT);
        wr_swirq = bus_wen && (bus_addr == A_SWIRQ);
        wr_cfg   = bus_wen && (bus_addr == A_CFG);
    end

    wdt_regs #(.TMR_W(TMR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .strap_i(strap_i), .wdata_i(bus_wdata),
        .wr_tmo_i(wr_tmo), .wr_ctrl1_i(wr_c1), .wr_ctrl2_i(wr_c2),
        .wr_din_i(wr_din), .wr_dout_i(wr_dout), .wr_swirq_i(wr_swirq),
        .wr_cfg_i(wr_cfg), .tmo_o(tmo), .halt_o(halt), .lock_o(lock),
        .ctrl2_o(ctrl2), .din_o(din), .dout_o(dout), .swirq_o(swirq),
        .strap_o(strap_q), .noreboot_o(noreboot)
    );

    wdt_countdown #(.CNT_W(TMR_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .load_i(wr_cnt), .tmo_i(tmo),
        .run_i(!halt), .tick_i(tick_i), .cnt_o(cnt), .expire_o(expire)
    );

    wdt_status #(.S1_W(S1_W), .S2_W(S2_W)) stat_i (
        .clk(clk), .rst_n(rst_n), .expire_i(expire),
        .set_smi_i(wr_din), .set_int_i(wr_dout), .noreboot_i(noreboot),
        .wr_s1_i(wr_s1), .wr_s2_i(wr_s2),
        .clr_s1_i(bus_wdata[S1_W-1:0]), .clr_s2_i(bus_wdata[S2_W-1:0]),
        .s1_o(s1), .s2_o(s2), .reboot_o(reboot_o)
    );

    // Combinational read mux over the address map.
    always_comb begin
        case (bus_addr)
            A_COUNT: bus_rdata = {{PAD_T{1'b0}}, cnt};
            A_TMO:   bus_rdata = {{PAD_T{1'b0}}, tmo};
            A_STAT1: bus_rdata = {{(DATA_W-S1_W){1'b0}}, s1};
            A_STAT2: bus_rdata = {{(DATA_W-S2_W){1'b0}}, s2};
            A_CTRL1: bus_rdata = {{(DATA_W-2){1'b0}}, lock, halt};
            A_CTRL2: bus_rdata = ctrl2;
            A_DIN:   bus_rdata = {{PAD_B{1'b0}}, din};
            A_DOUT:  bus_rdata = {{PAD_B{1'b0}}, dout};
            A_SWIRQ: bus_rdata = {{PAD_B{1'b0}}, swirq};
            A_CFG:   bus_rdata = {{(DATA_W-1){1'b0}}, noreboot};
            default: bus_rdata = '0;
        endcase
    end

    assign irq_o = |s1;

    // R8
    strap_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strap_q |-> !reboot_o);
endmodule

// File: tb/sys_watchdog_tb.sv
module sys_watchdog_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wen = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        tick_i = 1'b0;
    logic        strap_i = 1'b0;
    logic        irq_o, reboot_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string cur_tag = "R1";

    always #10 clk = ~clk;

    sys_watchdog dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_i(tick_i),
        .strap_i(strap_i), .irq_o(irq_o), .reboot_o(reboot_o)
    );

    // Behavioural reference model state.
    int m_cnt, m_tmo, m_s1, m_s2, m_halt, m_lock, m_c2, m_din, m_dout;
    int m_swirq, m_strap, m_nrb, m_reboot;

    function automatic int m_read(input int a);
        case (a)
            0: return m_cnt;
            1: return m_tmo;
            2: return m_s1;
            3: return m_s2;
            4: return m_lock * 2 + m_halt;
            5: return m_c2;
            6: return m_din;
            7: return m_dout;
            8: return m_swirq;
            9: return (m_strap | m_nrb);
            default: return 0;
        endcase
    endfunction

    // Model update on each rising edge from the stable inputs.
    always @(posedge clk) begin
        int a, d, exp_now, old_to, nrb_now, reload;
        if (!rst_n) begin
            m_cnt = 0; m_tmo = 4; m_s1 = 0; m_s2 = 0; m_halt = 0; m_lock = 0;
            m_c2 = 8; m_din = 0; m_dout = 0; m_swirq = 3; m_nrb = 0;
            m_strap = strap_i; m_reboot = 0;
        end else begin
            a = bus_wen ? int'(bus_addr) : -1;
            d = int'(bus_wdata);
            exp_now = 0;
            old_to  = m_s1 % 2;
            nrb_now = m_strap | m_nrb;
            reload  = (m_tmo == 0) ? 1 : m_tmo;
            if (a == 0) m_cnt = reload;
            else if (m_halt == 0 && tick_i && m_cnt != 0) begin
                if (m_cnt == 1) begin exp_now = 1; m_cnt = reload; end
                else m_cnt = m_cnt - 1;
            end
            if (a == 1) m_tmo = d % 1024;
            if (a == 2) m_s1 = m_s1 & ~(d & 7);
            if (a == 3) m_s2 = m_s2 & ~(d & 3);
            if (exp_now) m_s1 = m_s1 | 1;
            if (a == 6) begin m_s1 = m_s1 | 2; m_din = d % 256; end
            if (a == 7) begin m_s1 = m_s1 | 4; m_dout = d % 256; end
            if (exp_now && old_to) m_s2 = 3;
            m_reboot = (exp_now && old_to && !nrb_now) ? 1 : 0;
            if (a == 4) begin m_halt = d % 2; if ((d / 2) % 2) m_lock = 1; end
            if (a == 5) m_c2 = d;
            if (a == 8) m_swirq = d % 256;
            if (a == 9) m_nrb = d % 2;
        end
    end

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    // Cycle-by-cycle comparison against the model, away from the edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk({cur_tag, " rdata"}, int'(bus_rdata), m_read(int'(bus_addr)));
            chk("R6 irq", int'(irq_o), (m_s1 != 0) ? 1 : 0);
            chk("R7 reboot", int'(reboot_o), m_reboot);
        end
    end

    task automatic wr(input int a, input int d);
        @(posedge clk); #2;
        bus_wen = 1'b1; bus_addr = 4'(a); bus_wdata = 16'(d);
        @(posedge clk); #2;
        bus_wen = 1'b0;
    endtask

    task automatic rd_exp(input int a, input int exp, input string tag);
        @(posedge clk); #2;
        bus_addr = 4'(a);
        @(negedge clk);
        chk(tag, int'(bus_rdata), exp);
    endtask

    task automatic ticks(input int n);
        @(posedge clk); #2;
        tick_i = 1'b1;
        repeat (n) @(posedge clk);
        #2 tick_i = 1'b0;
    endtask

    task automatic do_reset(input bit strap);
        @(posedge clk); #2;
        rst_n = 1'b0; strap_i = strap;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
    endtask

    int rb_seen;
    always @(negedge clk) if (reboot_o) rb_seen++;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset(1'b0);
        // R1 reset values
        cur_tag = "R1";
        rd_exp(0, 0, "R1 count");   rd_exp(1, 4, "R1 timeout");
        rd_exp(2, 0, "R1 stat1");   rd_exp(3, 0, "R1 stat2");
        rd_exp(4, 0, "R1 ctrl1");   rd_exp(5, 8, "R1 ctrl2");
        rd_exp(6, 0, "R1 din");     rd_exp(7, 0, "R1 dout");
        rd_exp(8, 3, "R1 swirq");   rd_exp(9, 0, "R1 cfg");
        rd_exp(12, 0, "R1 unmapped");

        // R2 load and count down
        cur_tag = "R2";
        wr(1, 5); wr(0, 0);
        rd_exp(0, 5, "R2 loaded");
        ticks(2); rd_exp(0, 3, "R2 after 2 ticks");
        // R3 halt
        cur_tag = "R3";
        wr(4, 1); ticks(3); rd_exp(0, 3, "R3 halted");
        wr(4, 0); ticks(1); rd_exp(0, 2, "R3 resumed");
        // R4 N-1 ticks leave 1, Nth expires and reloads
        cur_tag = "R4";
        ticks(1); rd_exp(0, 1, "R4 count one");
        rd_exp(2, 0, "R4 no status yet");
        ticks(1); rd_exp(2, 1, "R6 first expiry");
        rd_exp(0, 5, "R4 reloaded");
        chk("R6 irq high", int'(irq_o), 1);
        // R7 second expiry with reboot pulse
        cur_tag = "R7";
        rb_seen = 0;
        ticks(5); rd_exp(3, 3, "R7 second+boot");
        chk("R7 one reboot pulse", rb_seen, 1);
        // R9 write back clears
        cur_tag = "R9";
        wr(2, 1); rd_exp(2, 0, "R9 stat1 cleared");
        wr(3, 3); rd_exp(3, 0, "R9 stat2 cleared");
        chk("R6 irq low", int'(irq_o), 0);

        // R8 software no-reboot with strap low
        cur_tag = "R8";
        wr(9, 1); rd_exp(9, 1, "R8 sw set");
        rb_seen = 0;
        wr(0, 0); ticks(10);
        rd_exp(3, 3, "R7 second with nrb");
        chk("R8 no reboot sw", rb_seen, 0);
        wr(9, 0); rd_exp(9, 0, "R8 sw clear");
        wr(2, 7); wr(3, 3);

        // R5 mask and max countdown
        cur_tag = "R5";
        wr(1, 16'hFFFF); rd_exp(1, 16'h03FF, "R5 masked");
        wr(0, 0); ticks(1022);
        rd_exp(0, 1, "R5 count one");
        rd_exp(2, 0, "R5 no status");
        ticks(1); rd_exp(2, 1, "R5 expired at 1023");
        wr(2, 1);

        // R2 zero timeout loads one
        cur_tag = "R2";
        wr(1, 0); wr(0, 0); rd_exp(0, 1, "R2 zero loads one");
        ticks(1); rd_exp(2, 1, "R4 zero expires on one tick");

        // R9 set wins over clear in the same cycle
        cur_tag = "R9";
        wr(1, 3); wr(0, 0); ticks(1); wr(2, 1);  // counter now 2, clean status
        rd_exp(2, 0, "R9 clean");
        ticks(1);
        @(posedge clk); #2;
        bus_wen = 1'b1; bus_addr = 4'd2; bus_wdata = 16'd1; tick_i = 1'b1;
        @(posedge clk); #2;
        bus_wen = 1'b0; tick_i = 1'b0;
        rd_exp(2, 1, "R9 set wins");
        wr(4, 1); wr(2, 7); wr(3, 3);

        // R10 lock sticky
        cur_tag = "R10";
        wr(4, 3); wr(4, 0); rd_exp(4, 2, "R10 lock stays");

        // R11 data registers set status bits
        cur_tag = "R11";
        wr(6, 16'h5A); rd_exp(2, 2, "R11 din sets smi");
        rd_exp(6, 16'h5A, "R11 din value");
        wr(7, 16'hA5); rd_exp(2, 6, "R11 dout sets int");
        chk("R11 irq", int'(irq_o), 1);
        wr(2, 6); rd_exp(2, 0, "R9 clear data bits");

        // R8 strap high
        do_reset(1'b1);
        cur_tag = "R8";
        rd_exp(9, 1, "R8 strap forces");
        wr(9, 0); rd_exp(9, 1, "R8 cannot clear");
        rb_seen = 0;
        wr(1, 2); wr(0, 0); ticks(4);
        rd_exp(3, 3, "R7 second under strap");
        chk("R8 no reboot strap", rb_seen, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule